// File: doc/BRIEF.md
# Symmetric Transposed-Form FIR Filter

This block is a fully parallel finite impulse response filter with constant coefficients. It accepts one signed sample on every active clock edge and delivers one filtered sample on every active clock edge. The filter is built in transposed form. Each incoming sample is multiplied by all coefficients at once, and the products move toward the output through a chain of registered adders. The impulse response is symmetric, so only the first half of the coefficients (plus the centre one when the tap count is odd) is supplied as parameters. The remaining taps reuse those values in mirror order, and each mirrored pair shares one constant product.

Each coefficient is a non-negative integer parameter that is read as a two's-complement number at the data width. A coefficient of zero builds no multiplier, and its adder stage becomes a plain register. The chain runs at full precision. The result is then resized to the chosen output width: low-order bits are dropped when the output is narrower, and the value is sign-extended when it is wider. Parameters also select the following:

- optional registers on the input and the output;
- the active clock edge;
- an asynchronous clear that can be absent, active high or active low.

Top module: `fir_sym_transposed`

## Requirements
- R1: Samples and coefficients are signed two's complement, `D_WIDTH` bits wide. A coefficient parameter is reduced to its low `D_WIDTH` bits, and a set top bit makes it negative. For example, 250 at 8 bits means -6, and 9 at 4 bits means -7.
- R2: For `TAPS` taps, `(TAPS+1)/2` coefficient entries are used. Tap k uses entry min(k, TAPS-1-k), so tap k and tap TAPS-1-k carry equal weights. This holds for both odd and even `TAPS`.
- R3: The output equals the sum over i of c_i·x(n-i). Here x(n) is the sample captured by the input stage, and the latency is one active edge from capture to the output with both I/O registers disabled.
- R4: The full-precision width is FULL = 2·`D_WIDTH` + ceil(log2(`TAPS`)). No stage of the adder chain overflows, even for full-scale inputs of either sign.
- R5: A zero coefficient builds no product. Its chain stage only delays the partial sum arriving from the next tap by one edge.
- R6: With `O_WIDTH`=0 the output is FULL bits wide. A larger `O_WIDTH` sign-extends the full result. A smaller `O_WIDTH` keeps the top `O_WIDTH` bits, which equals the full result arithmetically shifted right by FULL-`O_WIDTH`.
- R7: `CLR_MODE` selects the clear: 0 means none, 1 means active high and 2 means active low. The clear is asynchronous and zeroes every pipeline register, so the output reads 0 while the clear is active and the filter restarts from an all-zero history.
- R8: With `CLK_FALL`=0 every register captures on the rising edge. With `CLK_FALL`=1 every register captures on the falling edge.
- R9: `IO_REG`=1 adds one register stage before the chain and one after the resize step. This raises the latency from one edge to three.
- R10: After `TAPS`+2·`IO_REG` consecutive captures of a zero input, the output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Filter clock; the active edge is set by `CLK_FALL` |
| clr | input | 1 | Asynchronous clear; the polarity is set by `CLR_MODE` (ignored when `CLR_MODE`=0) |
| din | input | D_WIDTH | Signed input sample |
| dout | output | OUT_W | Filtered, resized output; OUT_W is FULL when `O_WIDTH`=0, otherwise `O_WIDTH` |

## Verification
The assertions check four properties on every cycle:

- every partial sum of the chain stays within the bound set by the magnitudes of the coefficients still ahead of it;
- zero-coefficient stages only delay their neighbour's sum;
- the input register mirrors the input;
- the widened output bits agree with the sign, and the output is zero once enough zero samples have been captured.

The actual filter values cannot be seen from any single cycle; only the bench scenarios show them. These include the mirrored impulse response, truncation and sign extension against an arithmetic model, falling-edge timing and the restart after a mid-run clear. They run on three configurations: odd, even and very short tap counts, with negative and zero coefficients.

// File: rtl/fir_sym_pkg.sv
package fir_sym_pkg;

    // Number of coefficient slots a parameter list can carry (64 taps max).
    localparam int COEF_SLOTS = 32;

    // Interpret a raw non-negative parameter as a dw-bit two's-complement value.
    function automatic int coef_signed(int raw, int dw);
        int m;
        m = raw & ((1 << dw) - 1);
        if (m >= (1 << (dw - 1)))
            m = m - (1 << dw);
        return m;
    endfunction

    // Mirrored slot used by tap k of a taps-long symmetric filter.
    function automatic int tap_slot(int k, int taps);
        return (k < taps - 1 - k) ? k : taps - 1 - k;
    endfunction

    // Number of distinct coefficient slots.
    function automatic int uniq_count(int taps);
        return taps / 2 + taps % 2;
    endfunction

    // Full-precision result width.
    function automatic int full_width(int dw, int taps);
        return 2 * dw + $clog2(taps);
    endfunction

    // Output width after the zero-means-full rule.
    function automatic int out_width(int ow, int full);
        return (ow == 0) ? full : ow;
    endfunction

endpackage

// File: rtl/fir_stage_reg.sv
module fir_stage_reg #(
    parameter int W        = 8,
    parameter bit CLK_FALL = 1'b0,
    parameter int CLR_MODE = 1
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic clr_act;

    generate
        if (CLR_MODE == 1) begin : g_clr_high
            assign clr_act = clr;
        end else if (CLR_MODE == 2) begin : g_clr_low
            assign clr_act = ~clr;
        end else begin : g_clr_none
            logic unused_clr;
            assign unused_clr = clr;
            assign clr_act    = 1'b0;
        end
    endgenerate

    generate
        if (CLK_FALL) begin : g_fall
            always_ff @(negedge clk or posedge clr_act) begin
                if (clr_act)
                    q <= '0;
                else
                    q <= d;
            end
        end else begin : g_rise
            always_ff @(posedge clk or posedge clr_act) begin
                if (clr_act)
                    q <= '0;
                else
                    q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/fir_const_mult.sv
module fir_const_mult #(
    parameter int DW       = 8,
    parameter int AW       = 19,
    parameter int COEF_VAL = 1
) (
    input  logic [DW-1:0] x,
    output logic [AW-1:0] p
);

    localparam logic signed [AW-1:0] CW = AW'(COEF_VAL);

    logic signed [AW-1:0] xw;

    assign xw = AW'($signed(x));
    assign p  = AW'(xw * CW);

endmodule

// File: rtl/fir_tap_cell.sv
module fir_tap_cell #(
    parameter int AW        = 19,
    parameter bit COEF_ZERO = 1'b0,
    parameter bit CLK_FALL  = 1'b0,
    parameter int CLR_MODE  = 1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [AW-1:0] prod,
    input  logic [AW-1:0] sum_in,
    output logic [AW-1:0] sum_out
);

    logic [AW-1:0] nxt;

    generate
        if (COEF_ZERO) begin : g_pass
            logic unused_prod;
            assign unused_prod = ^prod;
            assign nxt         = sum_in;
        end else begin : g_add
            assign nxt = sum_in + prod;
        end
    endgenerate

    fir_stage_reg #(
        .W       (AW),
        .CLK_FALL(CLK_FALL),
        .CLR_MODE(CLR_MODE)
    ) u_acc (
        .clk(clk),
        .clr(clr),
        .d  (nxt),
        .q  (sum_out)
    );

endmodule

// File: rtl/fir_resize.sv
module fir_resize #(
    parameter int IW = 19,
    parameter int OW = 19
) (
    input  logic [IW-1:0] a,
    output logic [OW-1:0] y
);

    generate
        if (OW >= IW) begin : g_extend
            assign y = OW'($signed(a));
        end else begin : g_trunc
            logic unused_low;
            assign unused_low = ^a[IW-OW-1:0];
            assign y          = a[IW-1 -: OW];
        end
    endgenerate

endmodule

// File: rtl/fir_sym_transposed.sv
module fir_sym_transposed
    import fir_sym_pkg::*;
#(
    parameter int D_WIDTH            = 8,
    parameter int TAPS               = 7,
    parameter int COEFS [COEF_SLOTS] = '{0: 3, 1: 250, 2: 0, 3: 100, default: 0},
    parameter int O_WIDTH            = 0,
    parameter bit IO_REG             = 1'b1,
    parameter bit CLK_FALL           = 1'b0,
    parameter int CLR_MODE           = 1,
    localparam int FULL_W            = full_width(D_WIDTH, TAPS),
    localparam int OUT_W             = out_width(O_WIDTH, FULL_W)
) (
    input  logic               clk,
    input  logic               clr,
    input  logic [D_WIDTH-1:0] din,
    output logic [OUT_W-1:0]   dout
);

    localparam int UNIQ  = uniq_count(TAPS);
    localparam int QUIET = TAPS + 2 * int'(IO_REG);
    localparam int QW    = $clog2(QUIET + 1);

    // Largest magnitude the partial sum leaving tap k can reach.
    function automatic longint tail_bound(int k);
        longint acc;
        int     c;
        acc = 0;
        for (int j = k; j < TAPS; j++) begin
            c   = coef_signed(COEFS[tap_slot(j, TAPS)], D_WIDTH);
            acc = acc + longint'((c < 0) ? -c : c) * (longint'(1) << (D_WIDTH - 1));
        end
        return acc;
    endfunction

    logic [D_WIDTH-1:0] x_core;
    logic [FULL_W-1:0]  prods [UNIQ];
    logic [FULL_W-1:0]  stage [TAPS+1];
    logic [OUT_W-1:0]   sized;

    // ---------------------------------------------------------------- input
    generate
        if (IO_REG) begin : g_in_reg
            fir_stage_reg #(
                .W       (D_WIDTH),
                .CLK_FALL(CLK_FALL),
                .CLR_MODE(CLR_MODE)
            ) u_in (
                .clk(clk),
                .clr(clr),
                .d  (din),
                .q  (x_core)
            );
        end else begin : g_in_wire
            assign x_core = din;
        end
    endgenerate

    // ------------------------------------------ one product per unique slot
    generate
        for (genvar s = 0; s < UNIQ; s++) begin : g_prod
            localparam int CV = coef_signed(COEFS[s], D_WIDTH);
            if (CV == 0) begin : g_none
                assign prods[s] = '0;
            end else begin : g_mult
                fir_const_mult #(
                    .DW      (D_WIDTH),
                    .AW      (FULL_W),
                    .COEF_VAL(CV)
                ) u_mul (
                    .x(x_core),
                    .p(prods[s])
                );
            end
        end
    endgenerate

    // --------------------------------------------- transposed adder chain
    assign stage[TAPS] = '0;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            localparam int SLOT = tap_slot(k, TAPS);
            localparam bit ZERO = (coef_signed(COEFS[SLOT], D_WIDTH) == 0);
            fir_tap_cell #(
                .AW       (FULL_W),
                .COEF_ZERO(ZERO),
                .CLK_FALL (CLK_FALL),
                .CLR_MODE (CLR_MODE)
            ) u_cell (
                .clk    (clk),
                .clr    (clr),
                .prod   (prods[SLOT]),
                .sum_in (stage[k+1]),
                .sum_out(stage[k])
            );
        end
    endgenerate

    // -------------------------------------------------------------- output
    fir_resize #(
        .IW(FULL_W),
        .OW(OUT_W)
    ) u_size (
        .a(stage[0]),
        .y(sized)
    );

    generate
        if (IO_REG) begin : g_out_reg
            fir_stage_reg #(
                .W       (OUT_W),
                .CLK_FALL(CLK_FALL),
                .CLR_MODE(CLR_MODE)
            ) u_out (
                .clk(clk),
                .clr(clr),
                .d  (sized),
                .q  (dout)
            );
        end else begin : g_out_wire
            assign dout = sized;
        end
    endgenerate

    // ----------------------------------------------------- checking support
    logic          ck_s;
    logic          clr_act;
    logic          past_ok;
    logic [QW-1:0] zcnt;

    assign ck_s    = CLK_FALL ? ~clk : clk;
    assign clr_act = (CLR_MODE == 1) ? clr : ((CLR_MODE == 2) ? ~clr : 1'b0);

    always_ff @(posedge ck_s or posedge clr_act) begin
        if (clr_act)
            past_ok <= 1'b0;
        else
            past_ok <= 1'b1;
    end

    always_ff @(posedge ck_s or posedge clr_act) begin
        if (clr_act)
            zcnt <= QW'(QUIET);
        else if (din != '0)
            zcnt <= '0;
        else if (zcnt != QW'(QUIET))
            zcnt <= zcnt + 1'b1;
    end

    // R10
    quiet_out_chk: assert property (@(posedge ck_s) disable iff (clr_act)
        (zcnt == QW'(QUIET)) |-> (dout == '0));

    generate
        if (IO_REG) begin : g_in_chk
            // R9
            in_stage_chk: assert property (@(posedge ck_s) disable iff (clr_act || !past_ok)
                x_core == $past(din));
        end
        if (OUT_W > FULL_W) begin : g_sext_chk
            // R6
            sign_ext_chk: assert property (@(posedge ck_s) disable iff (clr_act)
                ($countones(dout[OUT_W-1 -: OUT_W-FULL_W+1]) == 0) ||
                ($countones(dout[OUT_W-1 -: OUT_W-FULL_W+1]) == OUT_W-FULL_W+1));
        end
        for (genvar k = 0; k < TAPS; k++) begin : g_stage_chk
            localparam longint BND = tail_bound(k);
            // R4
            stage_range_chk: assert property (@(posedge ck_s) disable iff (clr_act)
                (longint'($signed(stage[k])) <= BND) &&
                (longint'($signed(stage[k])) >= -BND));
            if (coef_signed(COEFS[tap_slot(k, TAPS)], D_WIDTH) == 0) begin : g_zero
                // R5
                zero_tap_chk: assert property (@(posedge ck_s) disable iff (clr_act || !past_ok)
                    stage[k] == $past(stage[k+1]));
            end
        end
    endgenerate

endmodule

// File: tb/sim_fir_sym_transposed.sv
module sim_fir_sym_transposed;

    logic        clk = 1'b0;
    logic        clr;
    logic [7:0]  x8;
    logic [3:0]  x4;
    logic [18:0] y0;
    logic [11:0] y1;
    logic [15:0] y2;

    int nchk = 0;
    int nerr = 0;

    // 50 MHz: 20 ns period; rising edges at 10+20k, falling at 20k.
    always #10 clk = ~clk;

    // Config A: 7 taps (odd), weights 3,-6,0,100,0,-6,3; full 19-bit out; I/O regs; rising.
    fir_sym_transposed #(
        .D_WIDTH(8), .TAPS(7),
        .COEFS('{0: 3, 1: 250, 2: 0, 3: 100, default: 0}),
        .O_WIDTH(0), .IO_REG(1'b1), .CLK_FALL(1'b0), .CLR_MODE(1)
    ) u0 (.clk(clk), .clr(clr), .din(x8), .dout(y0));

    // Config B: 6 taps (even), weights -128,5,-1,-1,5,-128; 12 of 19 bits; no I/O regs; falling; clear low.
    fir_sym_transposed #(
        .D_WIDTH(8), .TAPS(6),
        .COEFS('{0: 128, 1: 5, 2: 255, default: 0}),
        .O_WIDTH(12), .IO_REG(1'b0), .CLK_FALL(1'b1), .CLR_MODE(2)
    ) u1 (.clk(clk), .clr(~clr), .din(x8), .dout(y1));

    // Config C: 3 taps, 4-bit, weights 7,-7,7; 10-bit full widened to 16; I/O regs; rising.
    fir_sym_transposed #(
        .D_WIDTH(4), .TAPS(3),
        .COEFS('{0: 7, 1: 9, default: 0}),
        .O_WIDTH(16), .IO_REG(1'b1), .CLK_FALL(1'b0), .CLR_MODE(1)
    ) u2 (.clk(clk), .clr(clr), .din(x4), .dout(y2));

    int k0 [7] = '{3, -6, 0, 100, 0, -6, 3};
    int k1 [6] = '{-128, 5, -1, -1, 5, -128};
    int k2 [3] = '{7, -7, 7};
    int h8 [16];
    int h4 [16];

    function automatic int ref0(int lag);
        int s = 0;
        for (int i = 0; i < 7; i++) s += k0[i] * h8[lag+i];
        return s;
    endfunction

    function automatic int ref1(int lag);
        int s = 0;
        for (int i = 0; i < 6; i++) s += k1[i] * h8[lag+i];
        return s;
    endfunction

    function automatic int ref2(int lag);
        int s = 0;
        for (int i = 0; i < 3; i++) s += k2[i] * h4[lag+i];
        return s;
    endfunction

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    // Compare all three outputs against the arithmetic model.
    // Lag: rising configs with I/O regs see x two drives back; falling config one back.
    task automatic compare(input string tag);
        chk(tag, "u0", int'($signed(y0)), ref0(2));
        chk(tag, "u1", int'($signed(y1)), ref1(1) >>> 7);
        chk(tag, "u2", int'($signed(y2)), ref2(2));
    endtask

    task automatic cyc(input int v8, input int v4, input string tag);
        #5;
        x8 = 8'(v8);
        x4 = 4'(v4);
        for (int i = 15; i > 0; i--) begin
            h8[i] = h8[i-1];
            h4[i] = h4[i-1];
        end
        h8[0] = v8;
        h4[0] = v4;
        #10;
        compare(tag);
        #5;
    endtask

    task automatic clr_cyc(input string tag);
        #5;
        clr = 1'b1;
        x8  = '0;
        x4  = '0;
        for (int i = 0; i < 16; i++) begin
            h8[i] = 0;
            h4[i] = 0;
        end
        #10;
        chk(tag, "u0 clear", int'(y0), 0);
        chk(tag, "u1 clear", int'(y1), 0);
        chk(tag, "u2 clear", int'(y2), 0);
        #5;
        clr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        clr = 1'b1;
        x8  = '0;
        x4  = '0;
        for (int i = 0; i < 16; i++) begin
            h8[i] = 0;
            h4[i] = 0;
        end
        // R7: outputs held at zero while clear is active
        for (int i = 0; i < 3; i++) clr_cyc("R7");

        // R2 R5 R9: unit impulse shows mirrored taps, the zero taps and the latency
        cyc(1, 1, "R2 R5 R9");
        for (int i = 0; i < 12; i++) cyc(0, 0, "R2 R5 R9");
        // R1: negative full-scale impulse against negative coefficients
        cyc(-128, -8, "R1 R2");
        for (int i = 0; i < 12; i++) cyc(0, 0, "R1 R2");

        // R4: full-scale steps of both signs
        for (int i = 0; i < 20; i++) cyc(127, 7, "R4");
        for (int i = 0; i < 20; i++) cyc(-128, -8, "R4");
        // R10: zero flush returns the outputs to 0
        for (int i = 0; i < 12; i++) cyc(0, 0, "R10");
        chk("R10", "u0 flushed", int'(y0), 0);
        chk("R10", "u1 flushed", int'(y1), 0);
        chk("R10", "u2 flushed", int'(y2), 0);

        // R3 R6 R8: random signed data on all three configurations
        for (int i = 0; i < 300; i++)
            cyc(int'($signed(8'($urandom))), int'($signed(4'($urandom))), "R3 R6 R8");

        // R6: every ordered pair of 4-bit samples on the sign-extended config
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                cyc(int'($signed(8'($urandom))), a - 8, "R6");
                cyc(int'($signed(8'($urandom))), b - 8, "R6");
            end
        end

        // R7: mid-run clear, then restart from an empty history
        clr_cyc("R7");
        clr_cyc("R7");
        for (int i = 0; i < 40; i++)
            cyc(int'($signed(8'($urandom))), int'($signed(4'($urandom))), "R7 R3");
        for (int i = 0; i < 12; i++) cyc(0, 0, "R10");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule